// File: doc/BRIEF.md
# Line Transmit Path Controller

This block picks the bit stream that drives a dual-rail line output. It runs in one synchronous clock domain. Each source of bit timing arrives as a one-cycle strobe: the system transmit clock, the recovered receive clock and the free-running reference clock. The selected stream is held in a register and presented as a positive-pulse enable and a negative-pulse enable, together with an output enable for the line drivers.

A two-bit loop code picks one of four routings. The first is normal operation. In digital local loopback, system transmit data is reflected onto the receive outputs. In remote loopback, recovered data is sent back out on the line. In local loopback, the transmitted stream feeds the receive outputs and the line is kept quiet. An alarm request replaces the system data with a continuous mark stream timed by the reference clock. A driver-fault input starts a back-off: the drivers are disabled for a fixed number of transmit bit periods and then retry. The back-off repeats for as long as the fault stays present. The fault state is kept internal.

Top module: `ltx_line_ctrl`

## Requirements
- R1: With loop code 00 (bit 1 = A, bit 0 = B), each `sys_tick` loads `{sys_pos, sys_neg}` into the line register, which appears on the pulse enables after that clock edge. `rx_pos/rx_neg/rx_tick` follow `rec_pos/rec_neg/rec_tick` combinationally.
- R2: With loop code 10, the line register loads `{rec_pos, rec_neg}` on `rec_tick`. `sys_pos`, `sys_neg`, `sys_tick` and `alarm_req` have no effect on the line. The receive outputs still follow the recovered inputs.
- R3: With loop code 01, `rx_pos/rx_neg/rx_tick` follow `sys_pos/sys_neg/sys_tick` combinationally. The line behaves as in R1, or as in R5 when the alarm is requested.
- R4: With loop code 11, `line_oe` and both pulse enables are low and `drv_fault` is not acted on. The receive outputs carry the line register, and `rx_tick` is the active transmit strobe delayed by one cycle.
- R5: When `alarm_req` is high and the loop code is not 10, every `ref_tick` loads a mark into the line register and the system rails are ignored. The request is sampled directly on each clock edge, with no latch.
- R6: Alarm marks alternate in polarity, and the first mark after reset is positive. The polarity sequence advances only on alarm marks.
- R7: A positive mark drives `line_pos_en`, a negative mark drives `line_neg_en`, and a zero drives neither. The two enables are never high together.
- R8: A source bit with both rails high is loaded as a zero. `dual_mark_err` is then high for exactly the cycle after that strobe.
- R9: When `drv_fault` is high while the drivers are enabled, `line_oe` and the pulse enables go low from the next cycle. They return after 35 active transmit strobes, counted on the strobe of the source then selected. The data register keeps updating during the back-off.
- R10: If the fault is still present when the drivers return, they are enabled for a single cycle and the back-off starts again.
- R11: After reset, the pulse enables and `dual_mark_err` are low, `line_oe` is high, and the alarm polarity is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_code | input | 2 | Loop routing code {A,B} |
| alarm_req | input | 1 | Request for the all-marks alarm stream |
| sys_pos | input | 1 | System transmit positive rail |
| sys_neg | input | 1 | System transmit negative rail |
| sys_tick | input | 1 | System transmit bit strobe |
| rec_pos | input | 1 | Recovered positive rail |
| rec_neg | input | 1 | Recovered negative rail |
| rec_tick | input | 1 | Recovered bit strobe |
| ref_tick | input | 1 | Reference clock bit strobe |
| drv_fault | input | 1 | Line driver fault indication |
| line_pos_en | output | 1 | Positive pulse enable (tip) |
| line_neg_en | output | 1 | Negative pulse enable (ring) |
| line_oe | output | 1 | Line driver enable |
| rx_pos | output | 1 | Receive positive rail after loop routing |
| rx_neg | output | 1 | Receive negative rail after loop routing |
| rx_tick | output | 1 | Receive bit strobe after loop routing |
| dual_mark_err | output | 1 | One-cycle flag for a bit with both rails high |

## Verification
Alarm insertion and the driver back-off can act in the same cycle: a fault arrives while the reference clock is timing an alarm mark. The back-off then counts reference strobes, and the hidden alarm polarity keeps advancing while the drivers are off. To provoke this, the bench holds the fault high with the alarm on and reference strobes sparse. It judges the result with a bench-side model of strobe counts: the re-enable cycle must match, and the first visible mark after re-enable must carry the polarity implied by the total number of marks. A sweep over every loop code, alarm setting, rail pair and strobe combination then checks priority and routing cycle by cycle.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

   typedef enum logic [1:0] {
      LOOP_NONE    = 2'b00,
      LOOP_DIGITAL = 2'b01,
      LOOP_REMOTE  = 2'b10,
      LOOP_LOCAL   = 2'b11
   } loop_mode_e;

   typedef enum logic [1:0] {
      SRC_SYS = 2'd0,
      SRC_REC = 2'd1,
      SRC_ALM = 2'd2
   } tx_src_e;

   typedef struct packed {
      logic pos;
      logic neg;
   } rail_t;

   localparam rail_t RAIL_ZERO = '{pos: 1'b0, neg: 1'b0};

endpackage

// File: rtl/ltx_src_sel.sv
module ltx_src_sel
   import ltx_pkg::*;
(
   input  loop_mode_e mode,
   input  logic       alarm_req,
   input  rail_t      sys_bit,
   input  logic       sys_tick,
   input  rail_t      rec_bit,
   input  logic       rec_tick,
   input  logic       ref_tick,
   output tx_src_e    src,
   output logic       act_tick,
   output rail_t      cand
);

   // Remote loop outranks the alarm; the alarm outranks system data.
   always_comb begin
      if (mode == LOOP_REMOTE) begin
         src      = SRC_REC;
         act_tick = rec_tick;
         cand     = rec_bit;
      end else if (alarm_req) begin
         src      = SRC_ALM;
         act_tick = ref_tick;
         cand     = RAIL_ZERO;
      end else begin
         src      = SRC_SYS;
         act_tick = sys_tick;
         cand     = sys_bit;
      end
   end

endmodule

// File: rtl/ltx_alarm_gen.sv
module ltx_alarm_gen
   import ltx_pkg::*;
#(
   parameter bit ALARM_AMI = 1'b1
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  step,
   output rail_t mark
);

   generate
      if (ALARM_AMI) begin : g_ami
         logic neg_next_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    neg_next_q <= 1'b0;
            else if (step) neg_next_q <= ~neg_next_q;
         end

         assign mark = neg_next_q ? '{pos: 1'b0, neg: 1'b1}
                                  : '{pos: 1'b1, neg: 1'b0};

         // R6: polarity turns over on every alarm mark
         p_alarm_alternates_r6: assert property (@(posedge clk) disable iff (!rst_n)
            step |=> (mark.pos == $past(mark.neg)));
      end else begin : g_unipolar
         assign mark = '{pos: 1'b1, neg: 1'b0};
      end
   endgenerate

endmodule

// File: rtl/ltx_backoff.sv
module ltx_backoff #(
   parameter int BACKOFF_LEN = 35
)(
   input  logic clk,
   input  logic rst_n,
   input  logic act_tick,
   input  logic fault_qual,
   output logic drive
);

   localparam int CNT_W = $clog2(BACKOFF_LEN + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BACKOFF_LEN - 1);

   generate
      if (BACKOFF_LEN < 2) begin : g_bad_len
         $error("ltx_backoff: BACKOFF_LEN must be at least 2");
      end
   endgenerate

   logic             drive_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b1;
         cnt_q   <= '0;
      end else if (drive_q) begin
         if (fault_qual) begin
            drive_q <= 1'b0;
            cnt_q   <= '0;
         end
      end else if (act_tick) begin
         if (cnt_q == LAST) begin
            drive_q <= 1'b1;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign drive = drive_q;

   // R9: a fault seen while driving shuts the drivers next cycle
   p_fault_backs_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && fault_qual) |=> !drive);

   // R9: the back-off counter stays within its window
   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(BACKOFF_LEN));

   // R10: drivers only return on an active transmit strobe
   p_reenable_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive && !act_tick) |=> !drive);

endmodule

// File: rtl/ltx_line_ctrl.sv
module ltx_line_ctrl
   import ltx_pkg::*;
#(
   parameter int BACKOFF_LEN = 35,
   parameter bit ALARM_AMI   = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] loop_code,
   input  logic       alarm_req,
   input  logic       sys_pos,
   input  logic       sys_neg,
   input  logic       sys_tick,
   input  logic       rec_pos,
   input  logic       rec_neg,
   input  logic       rec_tick,
   input  logic       ref_tick,
   input  logic       drv_fault,
   output logic       line_pos_en,
   output logic       line_neg_en,
   output logic       line_oe,
   output logic       rx_pos,
   output logic       rx_neg,
   output logic       rx_tick,
   output logic       dual_mark_err
);

   loop_mode_e mode;
   rail_t      sys_bit, rec_bit, cand, mark, tx_q;
   tx_src_e    src;
   logic       act_tick, tick_q, err_q, drive, is_local;
   logic       cand_clash;

   assign mode     = loop_mode_e'(loop_code);
   assign sys_bit  = '{pos: sys_pos, neg: sys_neg};
   assign rec_bit  = '{pos: rec_pos, neg: rec_neg};
   assign is_local = (mode == LOOP_LOCAL);

   ltx_src_sel u_sel (
      .mode      (mode),
      .alarm_req (alarm_req),
      .sys_bit   (sys_bit),
      .sys_tick  (sys_tick),
      .rec_bit   (rec_bit),
      .rec_tick  (rec_tick),
      .ref_tick  (ref_tick),
      .src       (src),
      .act_tick  (act_tick),
      .cand      (cand)
   );

   ltx_alarm_gen #(.ALARM_AMI(ALARM_AMI)) u_alm (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (act_tick && (src == SRC_ALM)),
      .mark  (mark)
   );

   ltx_backoff #(.BACKOFF_LEN(BACKOFF_LEN)) u_bo (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_tick   (act_tick),
      .fault_qual (drv_fault && !is_local),
      .drive      (drive)
   );

   assign cand_clash = cand.pos && cand.neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= RAIL_ZERO;
         tick_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         tick_q <= act_tick;
         err_q  <= act_tick && (src != SRC_ALM) && cand_clash;
         if (act_tick) begin
            if (src == SRC_ALM) tx_q <= mark;
            else if (cand_clash) tx_q <= RAIL_ZERO;
            else tx_q <= cand;
         end
      end
   end

   assign line_oe       = drive && !is_local;
   assign line_pos_en   = tx_q.pos && line_oe;
   assign line_neg_en   = tx_q.neg && line_oe;
   assign dual_mark_err = err_q;

   always_comb begin
      unique case (mode)
         LOOP_DIGITAL: begin
            rx_pos  = sys_pos;
            rx_neg  = sys_neg;
            rx_tick = sys_tick;
         end
         LOOP_LOCAL: begin
            rx_pos  = tx_q.pos;
            rx_neg  = tx_q.neg;
            rx_tick = tick_q;
         end
         default: begin
            rx_pos  = rec_pos;
            rx_neg  = rec_neg;
            rx_tick = rec_tick;
         end
      endcase
   end

   // R7: never both pulse enables together
   p_one_rail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_pos_en && line_neg_en));

   // R2: in remote loop the line bit holds between recovered strobes
   p_remote_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LOOP_REMOTE && !rec_tick) |=> $stable(tx_q));

   // R5: an alarm strobe always loads a mark
   p_alarm_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != LOOP_REMOTE && alarm_req && ref_tick) |=> (tx_q.pos ^ tx_q.neg));

   // R8: a clash flag comes with a zero on the line register
   p_clash_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dual_mark_err |-> (!tx_q.pos && !tx_q.neg));

endmodule

// File: tb/ltx_line_ctrl_tb_top.sv
module ltx_line_ctrl_tb_top;

   localparam int CYC = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] loop_code = 2'b00;
   logic       alarm_req = 1'b0;
   logic       sys_pos = 1'b0, sys_neg = 1'b0, sys_tick = 1'b0;
   logic       rec_pos = 1'b0, rec_neg = 1'b0, rec_tick = 1'b0;
   logic       ref_tick = 1'b0, drv_fault = 1'b0;
   logic       line_pos_en, line_neg_en, line_oe;
   logic       rx_pos, rx_neg, rx_tick, dual_mark_err;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   int oe_hi = 0;

   // bench model state
   logic m_pos = 0, m_neg = 0, m_pol = 0, m_drive = 1, m_err = 0, m_tickq = 0;
   int   m_cnt = 0;

   always #(CYC/2) clk = ~clk;

   ltx_line_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .loop_code(loop_code), .alarm_req(alarm_req),
      .sys_pos(sys_pos), .sys_neg(sys_neg), .sys_tick(sys_tick),
      .rec_pos(rec_pos), .rec_neg(rec_neg), .rec_tick(rec_tick),
      .ref_tick(ref_tick), .drv_fault(drv_fault),
      .line_pos_en(line_pos_en), .line_neg_en(line_neg_en), .line_oe(line_oe),
      .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_tick(rx_tick),
      .dual_mark_err(dual_mark_err)
   );

   task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply(input logic [1:0] lc, input logic al, input logic [1:0] sp,
                        input logic [1:0] rp, input logic [2:0] tk, input logic flt);
      logic remote, loc, alm, act, both, e_oe;
      logic [2:0] erx;
      string tag;
      loop_code = lc; alarm_req = al;
      {sys_pos, sys_neg} = sp; {rec_pos, rec_neg} = rp;
      {ref_tick, rec_tick, sys_tick} = tk; drv_fault = flt;
      #1;
      // receive routing: R1 normal/remote, R3 digital loop, R4 local loop
      case (lc)
         2'b01:   erx = {sp, tk[0]};
         2'b11:   erx = {m_pos, m_neg, m_tickq};
         default: erx = {rp, tk[1]};
      endcase
      check({rx_pos, rx_neg, rx_tick} == erx,
            (lc == 2'b01) ? "R3 rx" : (lc == 2'b11) ? "R4 rx" : "R1/R2 rx",
            {1'b0, rx_pos, rx_neg, rx_tick}, {1'b0, erx});
      // model of one clock edge
      remote = (lc == 2'b10);
      loc    = (lc == 2'b11);
      alm    = !remote && al;
      act    = remote ? tk[1] : (al ? tk[2] : tk[0]);
      both   = remote ? (rp == 2'b11) : (sp == 2'b11);
      m_err  = act && !alm && both;
      m_tickq = act;
      if (m_drive) begin
         if (flt && !loc) begin m_drive = 0; m_cnt = 0; end
      end else if (act) begin
         if (m_cnt == 34) begin m_drive = 1; m_cnt = 0; end
         else m_cnt++;
      end
      if (act) begin
         if (alm) begin
            {m_pos, m_neg} = m_pol ? 2'b01 : 2'b10;
            m_pol = ~m_pol;
         end else if (both) {m_pos, m_neg} = 2'b00;
         else {m_pos, m_neg} = remote ? rp : sp;
      end
      @(negedge clk);
      e_oe = m_drive && !loc;
      if (!m_drive)    tag = "R9 line";
      else if (remote) tag = "R2 line";
      else if (loc)    tag = "R4 line";
      else if (al)     tag = "R5/R6 line";
      else             tag = "R1 line";
      check({line_oe, line_pos_en, line_neg_en} == {e_oe, m_pos & e_oe, m_neg & e_oe}, tag,
            {1'b0, line_oe, line_pos_en, line_neg_en}, {1'b0, e_oe, m_pos & e_oe, m_neg & e_oe});
      check(dual_mark_err == m_err, "R8 clash flag", {3'b0, dual_mark_err}, {3'b0, m_err});
      check(!(line_pos_en && line_neg_en), "R7 one rail", {2'b0, line_pos_en, line_neg_en}, 4'b0);
      if (line_oe) oe_hi++;
   endtask

   initial begin
      #(CYC * 190000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check({line_oe, line_pos_en, line_neg_en, dual_mark_err} == 4'b1000, "R11 reset",
            {line_oe, line_pos_en, line_neg_en, dual_mark_err}, 4'b1000);

      // R6: first alarm mark after reset is positive, then negative
      apply(2'b00, 1'b1, 2'b00, 2'b00, 3'b100, 1'b0);
      check(line_pos_en && !line_neg_en, "R6 first mark", {2'b0, line_pos_en, line_neg_en}, 4'b0010);
      apply(2'b00, 1'b1, 2'b00, 2'b00, 3'b100, 1'b0);
      check(!line_pos_en && line_neg_en, "R6 second mark", {2'b0, line_pos_en, line_neg_en}, 4'b0001);

      // sweep: loop code x alarm x system rails x recovered rails x strobes
      for (int lc = 0; lc < 4; lc++)
         for (int al = 0; al < 2; al++)
            for (int sp = 0; sp < 4; sp++)
               for (int rp = 0; rp < 4; rp++)
                  for (int tk = 0; tk < 8; tk++)
                     apply(2'(lc), 1'(al), 2'(sp), 2'(rp), 3'(tk), 1'b0);

      // R9: single fault pulse in normal mode, system strobe every cycle
      apply(2'b00, 1'b0, 2'b10, 2'b00, 3'b001, 1'b1);
      for (int i = 0; i < 40; i++) apply(2'b00, 1'b0, 2'(i % 3), 2'b00, 3'b001, 1'b0);

      // R4: fault ignored in local loop
      apply(2'b11, 1'b0, 2'b10, 2'b00, 3'b001, 1'b1);
      apply(2'b00, 1'b0, 2'b01, 2'b00, 3'b001, 1'b0);
      check(line_oe, "R4 fault ignored", {3'b0, line_oe}, 4'b0001);

      // R10: persistent fault, one-cycle retry windows
      oe_hi = 0;
      for (int i = 0; i < 72; i++) apply(2'b00, 1'b0, 2'b10, 2'b00, 3'b001, 1'b1);
      check(oe_hi == 2, "R10 retry count", 4'(oe_hi), 4'd2);
      for (int i = 0; i < 36; i++) apply(2'b00, 1'b0, 2'b10, 2'b00, 3'b001, 1'b0);

      // R9/R5 coincidence: fault during alarm with sparse reference strobes
      for (int i = 0; i < 150; i++)
         apply(2'b01, 1'b1, 2'b11, 2'b00, (i % 3 == 0) ? 3'b101 : 3'b001, (i < 120) ? 1'b1 : 1'b0);

      // R2: remote loop with changing system data, alarm and ticks ignored
      for (int i = 0; i < 64; i++)
         apply(2'b10, 1'(i % 2), 2'(i % 4), 2'((i / 4) % 3), 3'((i * 5) % 8), 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule